// File: doc/BRIEF.md
# Parallel Disk Register Port Decoder

This block is the device-side register access logic for a parallel disk-style host bus. The host drives two active-low group selects, a 3-bit register address and active-low read and write strobes, all asynchronous to the device clock. The block brings these into the device clock domain through two-flop synchronizers. It works out which register group and address an access targets, then stores write data into a small register file or returns read data toward the bus.

The command group holds a 16-bit data port at address 0 and 8-bit registers at addresses 1 to 7. The control group holds a single 8-bit register at one address. The bidirectional data bus is split into an input vector, an output vector and an output enable, which a pad ring combines into the tri-state bus. Every transfer is paced by the host's strobes, and the device has no way to stall a strobe. There is therefore no valid/ready interface and no back-pressure: each strobe edge, once synchronized, is taken in the cycle it is detected.

Top module: `dskreg_port`

## Requirements
- R1: After reset every stored register and the data port read back as zero, and `bus_oe` is low.
- R2: A write takes effect only after the synchronized rising edge of `wr_n`. The value stored is the bus value last sampled while `wr_n` was still low. Storage is unchanged while the strobe is held low, even if the bus value changes during that time.
- R3: In the command group (`cs_cmd_n` low), addresses 1 to 7 are 8-bit registers. A write stores `bus_in[7:0]` and discards the upper byte. A read returns the stored byte with `bus_out[15:8]` equal to zero.
- R4: In the command group, address 0 is a 16-bit data port. A write stores all of `bus_in[15:0]`, and a read returns all 16 bits.
- R5: The control group (`cs_ctl_n` low) holds one 8-bit register, at address 6 (parameter `CTL_ADDR`). Writes to the other control-group addresses are ignored, and reads of those addresses return zero.
- R6: An access made with both selects low, or with both selects high, changes no register and never raises `bus_oe`.
- R7: `bus_oe` rises on the third rising clock edge after `rd_n` falls, provided exactly one select is low. It falls on the third rising clock edge after `rd_n` rises.
- R8: While `bus_oe` stays high, `bus_out` holds the value captured when the read began.
- R9: A read whose synchronized start falls in the same cycle as a write commit returns the value the register held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_cmd_n | input | 1 | Active-low select of the command group |
| cs_ctl_n | input | 1 | Active-low select of the control group |
| addr | input | ADDR_W | Register address within the selected group |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| bus_in | input | BUS_W | Data bus value seen from the host |
| bus_out | output | BUS_W | Read data the device returns toward the bus |
| bus_oe | output | 1 | High while the device drives `bus_out` onto the bus |

## Verification
The write commit, triggered by a synchronized rising `wr_n`, and the read capture, triggered by a synchronized falling `rd_n`, can land in the same clock cycle. The bench provokes this by raising `wr_n` and lowering `rd_n` at the same instant, with one select and one address held. It expects the returned data to be the register's prior contents, and then expects a second read to return the newly written value. Sweeps over every address of both groups, and over both illegal select combinations, check decoding and storage against a model kept in the bench.

// File: rtl/dskreg_pkg.sv
package dskreg_pkg;
  localparam int DEF_ADDR_W = 3;
  localparam int DEF_BUS_W  = 16;
  localparam int DEF_REG_W  = 8;
  localparam int DEF_CTL_ADDR = 6;

  // group decoded from the two active-low selects: bit0 = command, bit1 = control
  typedef enum logic [1:0] {
    GRP_NONE = 2'b00,
    GRP_CMD  = 2'b01,
    GRP_CTL  = 2'b10,
    GRP_BOTH = 2'b11
  } grp_e;

  function automatic grp_e grp_of(input logic cmd_n, input logic ctl_n);
    return grp_e'({~ctl_n, ~cmd_n});
  endfunction

  function automatic logic grp_legal(input grp_e g);
    return (g == GRP_CMD) || (g == GRP_CTL);
  endfunction
endpackage

// File: rtl/dskreg_sync.sv
module dskreg_sync #(
  parameter int W = 8,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[0] <= RST_VAL;
          else        stage[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) stage[i] <= RST_VAL;
          else        stage[i] <= stage[i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/dskreg_strobe.sv
module dskreg_strobe
  import dskreg_pkg::*;
#(
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int BUS_W  = DEF_BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_s,
  input  logic              wr_s,
  input  grp_e              grp_s,
  input  logic [ADDR_W-1:0] addr_s,
  input  logic [BUS_W-1:0]  data_s,
  output logic              commit,
  output grp_e              w_grp,
  output logic [ADDR_W-1:0] w_addr,
  output logic [BUS_W-1:0]  w_data,
  output logic              rd_load,
  output logic              oe_q
);
  logic wr_d;
  logic rd_ok;

  // latest bus snapshot taken while the write strobe is still low
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      w_grp  <= GRP_NONE;
      w_addr <= '0;
      w_data <= '0;
    end else if (!wr_s) begin
      w_grp  <= grp_s;
      w_addr <= addr_s;
      w_data <= data_s;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_d <= 1'b1;
    else        wr_d <= wr_s;

  assign commit = wr_s && !wr_d && grp_legal(w_grp);

  assign rd_ok   = !rd_s && grp_legal(grp_s);
  assign rd_load = rd_ok && !oe_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= rd_ok;
endmodule

// File: rtl/dskreg_regs.sv
module dskreg_regs
  import dskreg_pkg::*;
#(
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int BUS_W    = DEF_BUS_W,
  parameter int REG_W    = DEF_REG_W,
  parameter int CTL_ADDR = DEF_CTL_ADDR,
  localparam int NREG    = 2 ** ADDR_W,
  localparam int ST_W    = BUS_W + (NREG - 1) * REG_W + REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  grp_e              w_grp,
  input  logic [ADDR_W-1:0] w_addr,
  input  logic [BUS_W-1:0]  w_data,
  input  grp_e              r_grp,
  input  logic [ADDR_W-1:0] r_addr,
  output logic [BUS_W-1:0]  rdata,
  output logic [ST_W-1:0]   state
);
  logic [BUS_W-1:0] port_q;
  logic [REG_W-1:0] cmd_q [NREG];
  logic [REG_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) port_q <= '0;
    else if (commit && w_grp == GRP_CMD && w_addr == '0) port_q <= w_data;

  assign cmd_q[0] = '0;

  genvar i;
  generate
    for (i = 1; i < NREG; i++) begin : g_cmd
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) cmd_q[i] <= '0;
        else if (commit && w_grp == GRP_CMD && w_addr == ADDR_W'(i))
          cmd_q[i] <= w_data[REG_W-1:0];
      assign state[BUS_W + (i-1)*REG_W +: REG_W] = cmd_q[i];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl_q <= '0;
    else if (commit && w_grp == GRP_CTL && w_addr == ADDR_W'(CTL_ADDR))
      ctl_q <= w_data[REG_W-1:0];

  assign state[BUS_W-1:0]         = port_q;
  assign state[ST_W-1 -: REG_W]   = ctl_q;

  always_comb begin
    rdata = '0;
    if (r_grp == GRP_CMD) begin
      if (r_addr == '0) rdata = port_q;
      else              rdata = BUS_W'(cmd_q[r_addr]);
    end else if (r_grp == GRP_CTL && r_addr == ADDR_W'(CTL_ADDR)) begin
      rdata = BUS_W'(ctl_q);
    end
  end
endmodule

// File: rtl/dskreg_port.sv
module dskreg_port
  import dskreg_pkg::*;
#(
  parameter int ADDR_W   = DEF_ADDR_W,
  parameter int BUS_W    = DEF_BUS_W,
  parameter int REG_W    = DEF_REG_W,
  parameter int CTL_ADDR = DEF_CTL_ADDR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_cmd_n,
  input  logic              cs_ctl_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [BUS_W-1:0]  bus_in,
  output logic [BUS_W-1:0]  bus_out,
  output logic              bus_oe
);
  localparam int NREG = 2 ** ADDR_W;
  localparam int ST_W = BUS_W + (NREG - 1) * REG_W + REG_W;
  localparam int SY_W = 4 + ADDR_W + BUS_W;
  localparam logic [SY_W-1:0] SY_RST = {4'b1111, {(ADDR_W + BUS_W){1'b0}}};

  logic [SY_W-1:0]   sy_q;
  logic              cmd_s, ctl_s, rd_s, wr_s;
  logic [ADDR_W-1:0] addr_s;
  logic [BUS_W-1:0]  data_s;
  grp_e              grp_s;

  logic              commit, rd_load, oe_q;
  grp_e              w_grp;
  logic [ADDR_W-1:0] w_addr;
  logic [BUS_W-1:0]  w_data;
  logic [BUS_W-1:0]  rdata;
  logic [ST_W-1:0]   state_flat;

  dskreg_sync #(.W(SY_W), .STAGES(2), .RST_VAL(SY_RST)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({cs_cmd_n, cs_ctl_n, rd_n, wr_n, addr, bus_in}),
    .q(sy_q)
  );

  assign {cmd_s, ctl_s, rd_s, wr_s, addr_s, data_s} = sy_q;
  assign grp_s = grp_of(cmd_s, ctl_s);

  dskreg_strobe #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) strobe_i (
    .clk(clk), .rst_n(rst_n),
    .rd_s(rd_s), .wr_s(wr_s), .grp_s(grp_s), .addr_s(addr_s), .data_s(data_s),
    .commit(commit), .w_grp(w_grp), .w_addr(w_addr), .w_data(w_data),
    .rd_load(rd_load), .oe_q(oe_q)
  );

  dskreg_regs #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .REG_W(REG_W), .CTL_ADDR(CTL_ADDR)) regs_i (
    .clk(clk), .rst_n(rst_n),
    .commit(commit), .w_grp(w_grp), .w_addr(w_addr), .w_data(w_data),
    .r_grp(grp_s), .r_addr(addr_s), .rdata(rdata), .state(state_flat)
  );

  // read data is captured once, as the synchronized read strobe falls
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       bus_out <= '0;
    else if (rd_load) bus_out <= rdata;

  assign bus_oe = oe_q;
endmodule

// File: rtl/dskreg_port_chk.sv
module dskreg_port_chk #(
  parameter int BUS_W = 16,
  parameter int ST_W  = 80
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_cmd_n,
  input logic             cs_ctl_n,
  input logic             rd_n,
  input logic             wr_n,
  input logic [BUS_W-1:0] bus_out,
  input logic             bus_oe,
  input logic [ST_W-1:0]  state
);
  // R7
  oe_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !$past(rd_n, 3));

  // R6
  oe_one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ($past(cs_cmd_n, 3) != $past(cs_ctl_n, 3)));

  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out));

  // R2
  wr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(state) |-> ($past(wr_n, 3) && !$past(wr_n, 4)));
endmodule

bind dskreg_port dskreg_port_chk #(.BUS_W(BUS_W), .ST_W(ST_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n),
  .rd_n(rd_n), .wr_n(wr_n), .bus_out(bus_out), .bus_oe(bus_oe), .state(state_flat)
);

// File: tb/dskreg_port_tb.sv
module dskreg_port_tb_top;
  localparam int CLK_PER = 10;
  localparam int AW = 3;
  localparam int BW = 16;
  localparam int CTLA = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_cmd_n = 1'b1, cs_ctl_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] bus_in = '0;
  logic [BW-1:0] bus_out;
  logic bus_oe;

  int n_chk = 0, n_bad = 0;
  logic [BW-1:0] m_cmd [8];
  logic [7:0] m_ctl;

  always #(CLK_PER/2) clk = ~clk;

  dskreg_port dut_i (
    .clk(clk), .rst_n(rst_n), .cs_cmd_n(cs_cmd_n), .cs_ctl_n(cs_ctl_n),
    .addr(addr), .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic bus_write(input logic cn, input logic tn, input logic [AW-1:0] a, input logic [BW-1:0] d);
    @(negedge clk);
    cs_cmd_n = cn; cs_ctl_n = tn; addr = a; bus_in = d;
    ticks(2); wr_n = 1'b0;
    ticks(4); wr_n = 1'b1;
    ticks(5); cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
    ticks(1);
  endtask

  task automatic bus_read(input string req, input logic cn, input logic tn, input logic [AW-1:0] a,
                          input logic exp_oe, input logic [BW-1:0] exp_d);
    @(negedge clk);
    cs_cmd_n = cn; cs_ctl_n = tn; addr = a;
    ticks(2); rd_n = 1'b0;
    ticks(2); check({req, " R7 oe not yet"}, BW'(bus_oe), '0);
    ticks(1); check({req, " R7 oe on time"}, BW'(bus_oe), BW'(exp_oe));
    if (exp_oe) check(req, bus_out, exp_d);
    ticks(2); rd_n = 1'b1;
    ticks(2); check({req, " R7 oe held"}, BW'(bus_oe), BW'(exp_oe));
    ticks(1); check({req, " R7 oe released"}, BW'(bus_oe), '0);
    cs_cmd_n = 1'b1; cs_ctl_n = 1'b1;
    ticks(1);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < 8; a++) bus_read({req, " cmd"}, 1'b0, 1'b1, AW'(a), 1'b1, m_cmd[a]);
    for (int a = 0; a < 8; a++)
      bus_read({req, " ctl"}, 1'b1, 1'b0, AW'(a), 1'b1, (a == CTLA) ? BW'(m_ctl) : '0);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m_cmd[i] = '0;
    m_ctl = '0;
    ticks(4);
    check("R1 oe in reset", BW'(bus_oe), '0);
    rst_n = 1'b1;
    ticks(2);
    read_all("R1 reset value");

    // R4 R3: write every command address, upper byte dropped except at address 0
    for (int a = 0; a < 8; a++) begin
      logic [BW-1:0] v = 16'hA5C3 ^ BW'(a * 16'h1357);
      bus_write(1'b0, 1'b1, AW'(a), v);
      m_cmd[a] = (a == 0) ? v : {8'h00, v[7:0]};
    end
    read_all("R3 R4 cmd sweep");

    // R5: control group, only CTLA stores
    for (int a = 0; a < 8; a++) begin
      logic [BW-1:0] v = 16'h3C00 | BW'(8'h40 + a * 8'h11);
      bus_write(1'b1, 1'b0, AW'(a), v);
      if (a == CTLA) m_ctl = v[7:0];
    end
    read_all("R5 ctl sweep");

    // R6: both or neither select low
    for (int a = 0; a < 8; a++) begin
      bus_write(1'b0, 1'b0, AW'(a), 16'hDEAD);
      bus_write(1'b1, 1'b1, AW'(a), 16'hBEEF);
    end
    for (int a = 0; a < 8; a += 3) begin
      bus_read("R6 both sel", 1'b0, 1'b0, AW'(a), 1'b0, '0);
      bus_read("R6 no sel", 1'b1, 1'b1, AW'(a), 1'b0, '0);
    end
    read_all("R6 unchanged");

    // R2: data changes while strobe low; last low sample wins
    @(negedge clk);
    cs_cmd_n = 1'b0; addr = 3'd3; bus_in = 16'h0011;
    ticks(2); wr_n = 1'b0;
    ticks(4); bus_in = 16'h0022;
    ticks(4); bus_in = 16'h0033;
    ticks(4); wr_n = 1'b1; bus_in = 16'h0044;
    ticks(5); cs_cmd_n = 1'b1;
    ticks(1);
    m_cmd[3] = 16'h0033;
    bus_read("R2 last low sample", 1'b0, 1'b1, 3'd3, 1'b1, m_cmd[3]);

    // R9: write commit and read start in the same cycle return the old value
    for (int a = 0; a < 2; a++) begin
      logic [BW-1:0] nv = (a == 0) ? 16'h9E71 : 16'h00B4;
      @(negedge clk);
      cs_cmd_n = 1'b0; addr = AW'(a * 5); bus_in = nv;
      ticks(2); wr_n = 1'b0;
      ticks(4); wr_n = 1'b1; rd_n = 1'b0;
      ticks(5);
      check("R9 collision old value", bus_out, m_cmd[a * 5]);
      check("R9 collision oe", BW'(bus_oe), 16'd1);
      rd_n = 1'b1;
      ticks(5); cs_cmd_n = 1'b1;
      ticks(1);
      m_cmd[a * 5] = (a == 0) ? nv : {8'h00, nv[7:0]};
      bus_read("R9 new value after", 1'b0, 1'b1, AW'(a * 5), 1'b1, m_cmd[a * 5]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule